// File: doc/BRIEF.md
# Accumulator Overflow Counter Unit

This block is a wide accumulator that adds, subtracts, compares and loads one operand per enabled cycle. A 16-bit status word sits beside it. That word carries the usual result flags and a 6-bit overflow counter in its top bits. When saturation is off, the counter keeps a net tally of wrap-arounds. In signed mode it counts signed overflows, up for a positive wrap and down for a negative one. In unsigned mode it counts carries out of additions and borrows out of subtractions. When saturation is on, a signed overflow clamps the accumulator to the nearest extreme value instead, and the counter holds.

A surrounding datapath issues one operation per cycle with `op_en`. It picks the counting mode with `cnt_unsigned` and can rewrite the mode and sticky-overflow bits through a status write port. Every result appears on `acc` and `status` one clock after the operation.

Top module: `acc_ovf_unit`

## Requirements
- R1: While `rst_n` is low, `acc` reads 0 and every bit of `status` reads 0.
- R2: With saturation off, an add leaves `acc + operand` modulo 2^32 in the accumulator, a subtract leaves `acc - operand`, and a load (`op_sel` = 3) copies `operand`. The other codes are 0 for add, 1 for subtract and 2 for compare.
- R3: In signed mode (`cnt_unsigned` = 0) with saturation off, an add or subtract that overflows past the largest positive value adds 1 to the counter. One that overflows past the most negative value subtracts 1.
- R4: With saturation on (status bit 1), a positively overflowing add or subtract leaves 0x7FFFFFFF in the accumulator and a negatively overflowing one leaves 0x80000000. The counter does not change for any operation while saturation is on.
- R5: In unsigned mode with saturation off, an add that carries out adds 1 to the counter, a subtract that borrows subtracts 1, and no signed overflow moves the counter.
- R6: The counter is a 6-bit two's-complement value in status bits 15..10. Incrementing 31 yields -32 (0b100000) and decrementing -32 yields 31.
- R7: A compare leaves the accumulator, the counter and V unchanged. It sets N, Z and C from `acc - operand`.
- R8: V (status bit 6) is set by any signed overflow of an add or subtract, in either mode. It stays set until a status write with bit 6 low clears it. An overflow in the same cycle as that write wins.
- R9: After an add, subtract or load, N (bit 5) and Z (bit 4) describe the final accumulator value, including any clamp. C (bit 3) is the carry out of an add and the borrow of a subtract or compare. A load leaves C unchanged.
- R10: A status write (`st_wr`) updates only V from bit 6, the saturation bit from bit 1 and the stored sign-extension bit from bit 0. Bits 9..7 and bit 2 always read 0, and the write leaves the counter, N, Z and C alone. The saturation bit in force for an operation is the value held before a write in the same cycle.
- R11: A load changes neither the counter nor V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Perform the operation in `op_sel` this cycle |
| op_sel | input | 2 | 0 add, 1 subtract, 2 compare, 3 load |
| operand | input | 32 | Second operand, or the load value |
| cnt_unsigned | input | 1 | 1 counts carries and borrows, 0 counts signed overflows |
| st_wr | input | 1 | Write status bits 6, 1 and 0 from `st_wdata` |
| st_wdata | input | 16 | Status write data |
| acc | output | 32 | Accumulator |
| status | output | 16 | Counter, V, N, Z, C, saturation and sign-extension bits |

## Verification
The bench builds the unit with its default 32-bit accumulator and 6-bit counter. At that counter width both wrap points are reached after a few dozen load-and-overflow pairs, so the sequences that push the counter across 31 and across -32 stay short. The 32-bit width is small enough for the bench's 64-bit arithmetic to detect overflow, carry and borrow independently of the design. Random runs bias the operands towards the two extremes so that overflows, clamps and mode switches occur densely.

// File: rtl/acc_ovf_pkg.sv
package acc_ovf_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_CMP  = 2'd2,
    OP_LOAD = 2'd3
  } acc_op_e;

  localparam int unsigned BIT_V   = 6;
  localparam int unsigned BIT_N   = 5;
  localparam int unsigned BIT_Z   = 4;
  localparam int unsigned BIT_C   = 3;
  localparam int unsigned BIT_OVM = 1;
  localparam int unsigned BIT_SXM = 0;
  localparam int unsigned LOW_W   = 10;
endpackage

// File: rtl/acc_ovf_alu.sv
module acc_ovf_alu
  import acc_ovf_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  acc_op_e          op_i,
  input  logic             sat_i,
  output logic [ACC_W-1:0] res_o,
  output logic [ACC_W-1:0] flag_val_o,
  output logic             cy_o,
  output logic             sov_o,
  output logic             sov_pos_o
);
  localparam logic [ACC_W-1:0] SAT_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_LO = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W:0]   sum_w;
  logic [ACC_W:0]   dif_w;
  logic [ACC_W-1:0] raw;
  logic             subtract;

  always_comb begin
    sum_w     = {1'b0, a_i} + {1'b0, b_i};
    dif_w     = {1'b0, a_i} - {1'b0, b_i};
    subtract  = (op_i == OP_SUB) || (op_i == OP_CMP);
    raw       = subtract ? dif_w[ACC_W-1:0] : sum_w[ACC_W-1:0];
    cy_o      = subtract ? dif_w[ACC_W] : sum_w[ACC_W];
    if (subtract)
      sov_o = (a_i[ACC_W-1] != b_i[ACC_W-1]) && (raw[ACC_W-1] != a_i[ACC_W-1]);
    else
      sov_o = (a_i[ACC_W-1] == b_i[ACC_W-1]) && (raw[ACC_W-1] != a_i[ACC_W-1]);
    if (op_i == OP_LOAD) sov_o = 1'b0;
    sov_pos_o = sov_o && !a_i[ACC_W-1];
    if (op_i == OP_LOAD)
      res_o = b_i;
    else if (sat_i && sov_o)
      res_o = sov_pos_o ? SAT_HI : SAT_LO;
    else
      res_o = raw;
    flag_val_o = (op_i == OP_CMP) ? raw : res_o;
  end
endmodule

// File: rtl/acc_ovf_counter.sv
module acc_ovf_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i && inc_i)      cnt_d = cnt_q + 1'b1;
    else if (en_i && dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && inc_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MIN));
  assert_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && dec_i && !inc_i && cnt_q == CNT_MIN) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/acc_ovf_unit.sv
module acc_ovf_unit
  import acc_ovf_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned CNT_W = 6,
  localparam int unsigned ST_W = CNT_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_en,
  input  logic [1:0]       op_sel,
  input  logic [ACC_W-1:0] operand,
  input  logic             cnt_unsigned,
  input  logic             st_wr,
  input  logic [ST_W-1:0]  st_wdata,
  output logic [ACC_W-1:0] acc,
  output logic [ST_W-1:0]  status
);
  localparam logic [ACC_W-1:0] SAT_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_LO = {1'b1, {(ACC_W-1){1'b0}}};

  acc_op_e          op;
  logic [ACC_W-1:0] acc_q, acc_d, res, flag_val;
  logic             cy, sov, sov_pos, is_arith;
  logic             v_q, n_q, z_q, c_q, ovm_q, sxm_q;
  logic             v_d, n_d, z_d, c_d, ovm_d, sxm_d;
  logic             cnt_en, cnt_inc, cnt_dec;
  logic [CNT_W-1:0] ovc;

  assign op       = acc_op_e'(op_sel);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  acc_ovf_alu #(.ACC_W(ACC_W)) u_alu (
    .a_i        (acc_q),
    .b_i        (operand),
    .op_i       (op),
    .sat_i      (ovm_q),
    .res_o      (res),
    .flag_val_o (flag_val),
    .cy_o       (cy),
    .sov_o      (sov),
    .sov_pos_o  (sov_pos)
  );

  always_comb begin
    cnt_en = op_en && is_arith && !ovm_q;
    if (cnt_unsigned) begin
      cnt_inc = (op == OP_ADD) && cy;
      cnt_dec = (op == OP_SUB) && cy;
    end else begin
      cnt_inc = sov && sov_pos;
      cnt_dec = sov && !sov_pos;
    end
  end

  acc_ovf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (cnt_en),
    .inc_i (cnt_inc),
    .dec_i (cnt_dec),
    .cnt_o (ovc)
  );

  always_comb begin
    acc_d = acc_q;
    n_d   = n_q;
    z_d   = z_q;
    c_d   = c_q;
    v_d   = st_wr ? st_wdata[BIT_V]   : v_q;
    ovm_d = st_wr ? st_wdata[BIT_OVM] : ovm_q;
    sxm_d = st_wr ? st_wdata[BIT_SXM] : sxm_q;
    if (op_en) begin
      if (op != OP_CMP) acc_d = res;
      n_d = flag_val[ACC_W-1];
      z_d = (flag_val == '0);
      if (op != OP_LOAD) c_d = cy;
      if (is_arith && sov) v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
    end else if (op_en) begin
      acc_q <= acc_d;
      n_q   <= n_d;
      z_q   <= z_d;
      c_q   <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      ovm_q <= 1'b0;
      sxm_q <= 1'b0;
    end else if (op_en || st_wr) begin
      v_q   <= v_d;
      ovm_q <= ovm_d;
      sxm_q <= sxm_d;
    end
  end

  assign acc    = acc_q;
  assign status = {ovc, 3'b000, v_q, n_q, z_q, c_q, 1'b0, ovm_q, sxm_q};

  assert_sat_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && is_arith && ovm_q && sov) |=>
      (acc_q == ($past(sov_pos) ? SAT_HI : SAT_LO)));
  assert_cnt_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && ovm_q) |=> $stable(ovc));
  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_CMP) |=> ($stable(acc_q) && $stable(ovc)));
  assert_v_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !st_wr) |=> v_q);
  assert_load_keeps_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op == OP_LOAD) |=> $stable(ovc));
endmodule

// File: tb/test_acc_ovf_unit.sv
module test_acc_ovf_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_en, cnt_unsigned, st_wr;
  logic [1:0]  op_sel;
  logic [31:0] operand;
  logic [15:0] st_wdata;
  logic [31:0] acc;
  logic [15:0] status;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_acc;
  logic [5:0]  m_cnt;
  logic        m_v, m_n, m_z, m_c, m_ovm, m_sxm;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_ovf_unit i_acc_ovf_unit (
    .clk, .rst_n, .op_en, .op_sel, .operand, .cnt_unsigned,
    .st_wr, .st_wdata, .acc, .status
  );

  function automatic logic [15:0] exp_status();
    return {m_cnt, 3'b000, m_v, m_n, m_z, m_c, 1'b0, m_ovm, m_sxm};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference model of one cycle, computed with wide signed arithmetic.
  task automatic model(input logic en, input logic [1:0] o, input logic [31:0] b,
                       input logic uns, input logic wr, input logic [15:0] wd);
    longint sa, sb, sr;
    longint unsigned ua, ub;
    logic   ovf, cy, sat;
    logic [31:0] raw, fin;
    sat = m_ovm;
    if (wr) begin m_v = wd[6]; m_ovm = wd[1]; m_sxm = wd[0]; end
    if (!en) return;
    sa = longint'($signed(m_acc)); sb = longint'($signed(b));
    ua = {32'd0, m_acc}; ub = {32'd0, b};
    if (o == 2'd0) begin sr = sa + sb; cy = ((ua + ub) >> 32) != 0; end
    else           begin sr = sa - sb; cy = ua < ub; end
    raw = (o == 2'd0) ? m_acc + b : m_acc - b;
    ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    case (o)
      2'd3: begin m_acc = b; m_n = b[31]; m_z = (b == 0); end
      2'd2: begin m_n = raw[31]; m_z = (raw == 0); m_c = cy; end
      default: begin
        fin = raw;
        if (ovf && sat) fin = (sr > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        if (!sat) begin
          if (uns) begin
            if (cy) m_cnt = (o == 2'd0) ? m_cnt + 6'd1 : m_cnt - 6'd1;
          end else if (ovf) begin
            m_cnt = (sr > 0) ? m_cnt + 6'd1 : m_cnt - 6'd1;
          end
        end
        if (ovf) m_v = 1'b1;
        m_acc = fin; m_n = fin[31]; m_z = (fin == 0); m_c = cy;
      end
    endcase
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input string tag, input logic en, input logic [1:0] o,
                      input logic [31:0] b, input logic uns,
                      input logic wr, input logic [15:0] wd);
    op_en = en; op_sel = o; operand = b; cnt_unsigned = uns; st_wr = wr; st_wdata = wd;
    model(en, o, b, uns, wr, wd);
    @(negedge clk);
    op_en = 1'b0; st_wr = 1'b0;
    check({tag, " acc"}, acc, m_acc);
    check({tag, " status"}, {16'd0, status}, {16'd0, exp_status()});
  endtask

  function automatic logic [31:0] pick_operand();
    case ($urandom % 5)
      0: return 32'h7FFF_FFFF - ($urandom % 4);
      1: return 32'h8000_0000 + ($urandom % 4);
      2: return $urandom % 16;
      3: return 32'hFFFF_FFFF - ($urandom % 4);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; op_en = 0; op_sel = 0; operand = 0; cnt_unsigned = 0; st_wr = 0; st_wdata = 0;
    m_acc = 0; m_cnt = 0; m_v = 0; m_n = 0; m_z = 0; m_c = 0; m_ovm = 0; m_sxm = 0;
    repeat (3) @(negedge clk);
    check("R1 reset acc", acc, 32'd0);
    check("R1 reset status", {16'd0, status}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 basic wrap arithmetic and load
    step("R2 load", 1, 2'd3, 32'h0000_0010, 0, 0, 0);
    step("R2 add", 1, 2'd0, 32'h0000_0005, 0, 0, 0);
    step("R2 sub", 1, 2'd1, 32'h0000_0020, 0, 0, 0);
    check("R9 borrow C", {31'd0, status[3]}, 32'd1);
    // R3 positive then negative signed overflow
    step("R3 load", 1, 2'd3, 32'h7FFF_FFFF, 0, 0, 0);
    step("R3 pos ovf", 1, 2'd0, 32'd1, 0, 0, 0);
    check("R3 cnt +1", {26'd0, status[15:10]}, 32'd1);
    step("R3 neg ovf", 1, 2'd1, 32'd1, 0, 0, 0);
    check("R3 cnt back", {26'd0, status[15:10]}, 32'd0);
    // R10 status write mask
    step("R10 write all", 0, 2'd0, 0, 0, 1, 16'hFFFF);
    check("R10 mask", {16'd0, status}, {16'd0, 6'd0, 3'b000, 1'b1, m_n, m_z, m_c, 1'b0, 2'b11});
    // R8 clear V with concurrent overflow: overflow wins (saturation on, counter frozen)
    step("R8 clear", 0, 2'd0, 0, 0, 1, 16'h0002);
    check("R8 cleared", {31'd0, status[6]}, 32'd0);
    step("R4 load", 1, 2'd3, 32'h7FFF_FFF0, 0, 0, 0);
    step("R4 R8 sat", 1, 2'd0, 32'h0000_0100, 0, 1, 16'h0002);
    check("R4 clamp hi", acc, 32'h7FFF_FFFF);
    check("R8 wins", {31'd0, status[6]}, 32'd1);
    step("R4 load lo", 1, 2'd3, 32'h8000_0005, 0, 0, 0);
    step("R4 sat lo", 1, 2'd1, 32'h0000_0100, 0, 0, 0);
    check("R4 clamp lo", acc, 32'h8000_0000);
    step("R4 off", 0, 2'd0, 0, 0, 1, 16'h0000);
    // R7 compare
    step("R7 cmp", 1, 2'd2, 32'h8000_0000, 0, 0, 0);
    check("R7 Z", {31'd0, status[4]}, 32'd1);
    // R6 wrap up through 31 -> -32
    for (int i = 0; i < 40; i++) begin
      step("R6 load", 1, 2'd3, 32'h7FFF_FFFF, 0, 0, 0);
      step("R6 up", 1, 2'd0, 32'h4000_0000, 0, 0, 0);
    end
    // R6 wrap down through -32 -> 31
    for (int i = 0; i < 70; i++) begin
      step("R6 load", 1, 2'd3, 32'h8000_0000, 0, 0, 0);
      step("R6 down", 1, 2'd1, 32'h0000_0001, 0, 0, 0);
    end
    // R5 unsigned carry / borrow counting
    step("R5 load", 1, 2'd3, 32'hFFFF_FFFF, 1, 0, 0);
    step("R5 carry", 1, 2'd0, 32'd2, 1, 0, 0);
    step("R5 borrow", 1, 2'd1, 32'd5, 1, 0, 0);
    step("R5 sov only", 1, 2'd3, 32'h7FFF_FFFF, 1, 0, 0);
    step("R5 no carry", 1, 2'd0, 32'd1, 1, 0, 0);
    // R11 load does not touch counter or V
    step("R11 load", 1, 2'd3, 32'h1234_5678, 0, 0, 0);

    // Random mix: R2 R3 R4 R5 R7 R8 R9 R11
    for (int i = 0; i < 4000; i++) begin
      logic        wr;
      logic [15:0] wd;
      wr = ($urandom % 8) == 0;
      wd = 16'($urandom);
      step("R2-mix random", ($urandom % 6) != 0, 2'($urandom), pick_operand(),
           1'($urandom), wr, wd);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule